// File: doc/BRIEF.md
# Byte-Lane Controller for a Split-Bank 16-bit Bus

This block sits between a core and a 16-bit memory bus built from two byte-wide banks. The low bank carries data bits 7:0 and holds the even byte addresses. The high bank carries bits 15:8 and holds the odd ones. The core asks for a byte or a word load or store at any 20-bit byte address. The controller turns each request into one or two bus cycles. Address bit 0 selects the low bank when it is 0, and an active-low high-bank enable selects the high bank. The controller places write bytes on the lane of the addressed bank and picks read bytes off the matching lane. When a request takes two cycles, it joins the two returned bytes into one word.

A word at an odd address cannot be moved in one cycle. It goes to the high bank first, at the requested address, and then to the low bank at the next address. The next address wraps from the top of the space to zero. Setting the `NARROW` parameter builds a variant for an 8-bit bus. That variant never enables the high bank, moves every byte on the low lane, and splits every word into two cycles. Each bus cycle is held until the bus acknowledges it. A one-cycle completion pulse then returns the read data.

Top module: `byte_lane_ctrl`

## Requirements
- R1: A byte request at an even address (16-bit build) makes one bus cycle with `bus_addr` equal to the request address, so its bit 0 is 0, and `bus_bhe_n`=1. Write data bits 7:0 go out on `bus_wdata[7:0]` with `bus_wdata[15:8]`=0. A read returns `{8'h00, bus_rdata[7:0]}`.
- R2: A byte request at an odd address (16-bit build) makes one bus cycle with `bus_addr[0]`=1 and `bus_bhe_n`=0. Write data bits 7:0 go out on `bus_wdata[15:8]` with `bus_wdata[7:0]`=0. A read returns `{8'h00, bus_rdata[15:8]}`. In every bus cycle of the 16-bit build at least one bank is selected.
- R3: A word request at an even address (16-bit build) makes a single bus cycle with `bus_addr[0]`=0 and `bus_bhe_n`=0. It carries all 16 write bits unchanged, and a read returns `bus_rdata` unchanged.
- R4: A word request at an odd address (16-bit build) makes two bus cycles. The first is at the request address with `bus_bhe_n`=0, and write bits 7:0 go on `bus_wdata[15:8]`. The second is at the address plus one with `bus_bhe_n`=1, and write bits 15:8 go on `bus_wdata[7:0]`.
- R5: For a two-cycle word read, result bits 7:0 are the byte from the first cycle's lane and result bits 15:8 are the byte from the second cycle's lane.
- R6: `req_ready` is 1 exactly when no request is in progress, including during reset, and `bus_cyc` is 0 then. `done` pulses for one cycle, in the cycle after the acknowledge of a request's last bus cycle, and never at any other time.
- R7: While `bus_cyc`=1 and `bus_ack`=0, the bus cycle and its address, enable, direction and write data stay unchanged into the next cycle.
- R8: With `NARROW`=1, `bus_bhe_n` is always 1 and all data uses lane 7:0. A byte takes one cycle at its address. A word takes two cycles: the low byte at the address, then the high byte at the address plus one.
- R9: The second cycle of a word at address 0xFFFFF is issued at address 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 2*LANE_W | Store data, byte in bits 7:0 for byte stores |
| bus_cyc | output | 1 | A bus cycle is being requested |
| bus_addr | output | ADDR_W | Cycle byte address; bit 0 is the low-bank select (active low) |
| bus_bhe_n | output | 1 | Active-low high-bank enable |
| bus_we | output | 1 | Cycle is a write |
| bus_wdata | output | 2*LANE_W | Write data steered onto the lanes |
| bus_ack | input | 1 | Bus completes the current cycle |
| bus_rdata | input | 2*LANE_W | Read data from the bus, sampled on `bus_ack` |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 2*LANE_W | Assembled load result, valid with `done` |

## Verification
The cycle-by-cycle reference compares every bus field, on every clock, against a queue of expected cycles. A wrong sequencer state therefore shows on the very next clock, as an extra, missing or misaddressed bus cycle, or as a `done` pulse one cycle off. A lane or enable mistake shows in the same cycle the bus cycle is presented. A lost or stale captured byte shows at the `done` of the affected two-cycle read, because the read values depend on the address. Running the 8-bit and 16-bit variants side by side on the same requests exposes any mix-up between the variants.

// File: rtl/blc_pkg.sv
package blc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } blc_state_e;

   typedef enum logic [1:0] {
      LANE_LO   = 2'd0,
      LANE_HI   = 2'd1,
      LANE_BOTH = 2'd2
   } blc_lane_e;

endpackage

// File: rtl/blc_bank_sel.sv
module blc_bank_sel
   import blc_pkg::*;
#(
   parameter int NARROW = 0
) (
   input  logic      a0_i,
   input  logic      whole_i,
   output blc_lane_e lane_o,
   output logic      bhe_n_o
);

   generate
      if (NARROW != 0) begin : g_narrow
         logic unused_sel;
         assign unused_sel = a0_i ^ whole_i;
         assign lane_o     = LANE_LO;
         assign bhe_n_o    = 1'b1;
      end else begin : g_wide
         always_comb begin
            if (whole_i)   lane_o = LANE_BOTH;
            else if (a0_i) lane_o = LANE_HI;
            else           lane_o = LANE_LO;
         end
         assign bhe_n_o = (lane_o == LANE_LO);
      end
   endgenerate

endmodule

// File: rtl/blc_wdata_steer.sv
module blc_wdata_steer
   import blc_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  blc_lane_e             lane_i,
   input  logic [LANE_W-1:0]     byte_i,
   input  logic [2*LANE_W-1:0]   word_i,
   output logic [2*LANE_W-1:0]   bus_o
);

   always_comb begin
      unique case (lane_i)
         LANE_HI:   bus_o = {byte_i, {LANE_W{1'b0}}};
         LANE_BOTH: bus_o = word_i;
         default:   bus_o = {{LANE_W{1'b0}}, byte_i};
      endcase
   end

endmodule

// File: rtl/blc_rdata_merge.sv
module blc_rdata_merge
   import blc_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  blc_lane_e             lane_i,
   input  logic                  cap_lo_i,
   input  logic                  fin_i,
   input  logic                  split_i,
   input  logic [2*LANE_W-1:0]   bus_rdata_i,
   output logic [2*LANE_W-1:0]   rd_data_o
);

   logic [LANE_W-1:0] pick;
   logic [LANE_W-1:0] lo_q;

   assign pick = (lane_i == LANE_HI) ? bus_rdata_i[2*LANE_W-1:LANE_W]
                                     : bus_rdata_i[LANE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q      <= '0;
         rd_data_o <= '0;
      end else begin
         if (cap_lo_i) lo_q <= pick;
         if (fin_i) begin
            if (lane_i == LANE_BOTH) rd_data_o <= bus_rdata_i;
            else if (split_i)        rd_data_o <= {pick, lo_q};
            else                     rd_data_o <= {{LANE_W{1'b0}}, pick};
         end
      end
   end

endmodule

// File: rtl/byte_lane_ctrl.sv
module byte_lane_ctrl
   import blc_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int LANE_W = 8,
   parameter int NARROW = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_word,
   input  logic                  req_write,
   input  logic [2*LANE_W-1:0]   req_wdata,
   output logic                  bus_cyc,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic                  bus_bhe_n,
   output logic                  bus_we,
   output logic [2*LANE_W-1:0]   bus_wdata,
   input  logic                  bus_ack,
   input  logic [2*LANE_W-1:0]   bus_rdata,
   output logic                  done,
   output logic [2*LANE_W-1:0]   rd_data
);

   localparam int BUS_W = 2 * LANE_W;

   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
      $error("byte_lane_ctrl: ADDR_W must lie in 2..32");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("byte_lane_ctrl: LANE_W must be positive");
   end
   if (NARROW != 0 && NARROW != 1) begin : g_bad_narrow
      $error("byte_lane_ctrl: NARROW must be 0 or 1");
   end

   blc_state_e          st_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                word_q;
   logic                we_q;
   logic [BUS_W-1:0]    wdata_q;
   logic                split_q;
   logic                done_q;

   logic [ADDR_W-1:0]   cyc_addr;
   logic                whole;
   blc_lane_e           lane;
   logic [LANE_W-1:0]   byte_val;
   logic                cap_lo;
   logic                fin;

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         word_q  <= 1'b0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         split_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  word_q  <= req_word;
                  we_q    <= req_write;
                  wdata_q <= req_wdata;
                  split_q <= req_word && ((NARROW != 0) || req_addr[0]);
                  st_q    <= ST_FIRST;
               end
            end
            ST_FIRST: begin
               if (bus_ack) begin
                  if (split_q) st_q <= ST_SECOND;
                  else begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
            end
            ST_SECOND: begin
               if (bus_ack) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign bus_cyc   = (st_q != ST_IDLE);
   assign cyc_addr  = (st_q == ST_SECOND) ? addr_q + ADDR_W'(1) : addr_q;
   assign whole     = word_q && !split_q;
   assign byte_val  = (st_q == ST_SECOND) ? wdata_q[BUS_W-1:LANE_W] : wdata_q[LANE_W-1:0];
   assign cap_lo    = (st_q == ST_FIRST) && bus_ack && split_q;
   assign fin       = bus_ack && ((st_q == ST_SECOND) || ((st_q == ST_FIRST) && !split_q));

   assign bus_addr  = cyc_addr;
   assign bus_we    = bus_cyc && we_q;
   assign done      = done_q;

   blc_bank_sel #(.NARROW(NARROW)) u_bank_sel (
      .a0_i    (cyc_addr[0]),
      .whole_i (whole),
      .lane_o  (lane),
      .bhe_n_o (bus_bhe_n)
   );

   blc_wdata_steer #(.LANE_W(LANE_W)) u_wdata_steer (
      .lane_i (lane),
      .byte_i (byte_val),
      .word_i (wdata_q),
      .bus_o  (bus_wdata)
   );

   blc_rdata_merge #(.LANE_W(LANE_W)) u_rdata_merge (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_i      (lane),
      .cap_lo_i    (cap_lo),
      .fin_i       (fin),
      .split_i     (split_q),
      .bus_rdata_i (bus_rdata),
      .rd_data_o   (rd_data)
   );

   // checks
   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_bhe_n) && $stable(bus_wdata))); // R7

   AST_SECOND_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FIRST && split_q && bus_ack) |=> (bus_cyc && bus_addr == $past(bus_addr) + ADDR_W'(1))); // R4 R9

   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_cyc && bus_ack)); // R6

   AST_READY_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_cyc); // R6

   if (NARROW != 0) begin : g_narrow_chk
      AST_NARROW_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
         bus_cyc |-> (bus_bhe_n && bus_wdata[BUS_W-1:LANE_W] == '0)); // R8
   end else begin : g_wide_chk
      AST_BANK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
         bus_cyc |-> !(bus_addr[0] && bus_bhe_n)); // R2
   end

endmodule

// File: tb/byte_lane_ctrl_ref.sv
module byte_lane_ctrl_ref #(
   parameter int NARROW = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [19:0] req_addr,
   input  logic        req_word,
   input  logic        req_write,
   input  logic [15:0] req_wdata,
   input  logic        req_ready,
   input  logic        bus_cyc,
   input  logic [19:0] bus_addr,
   input  logic        bus_bhe_n,
   input  logic        bus_we,
   input  logic [15:0] bus_wdata,
   input  logic        bus_ack,
   input  logic [15:0] bus_rdata,
   input  logic        done,
   input  logic [15:0] rd_data,
   output int          checks,
   output int          errors
);

   logic [19:0] q_addr[$];
   bit          q_bhe[$];
   logic [15:0] q_wd[$];
   int          q_lane[$];
   string       q_tag[$];

   bit          busy, held, is_wr, done_exp, done_wr;
   int          idx;
   logic [15:0] acc, rd_exp;
   string       res_tag;

   initial begin
      checks = 0;
      errors = 0;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input logic [19:0] a, input bit bhe, input logic [15:0] wd,
                       input int ln, input string tg);
      q_addr.push_back(a);
      q_bhe.push_back(bhe);
      q_wd.push_back(wd);
      q_lane.push_back(ln);
      q_tag.push_back(tg);
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         q_addr.delete(); q_bhe.delete(); q_wd.delete(); q_lane.delete(); q_tag.delete();
         busy = 0; held = 0; done_exp = 0; is_wr = 0; done_wr = 0; idx = 0;
         chk(bus_cyc == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R6", "reset state",
             {29'd0, bus_cyc, done, req_ready}, 32'h1);
      end else begin : run
         bit          old_busy;
         logic [19:0] a, a1;
         logic [7:0]  b;
         string       t;
         // compare
         chk(req_ready == !busy, "R6", "req_ready", req_ready, !busy);
         if (busy && q_addr.size() > 0) begin
            t = held ? "R7" : q_tag[0];
            chk(bus_cyc == 1'b1, t, "bus_cyc", bus_cyc, 1);
            chk(bus_addr == q_addr[0], t, "bus_addr", bus_addr, q_addr[0]);
            chk(bus_bhe_n == q_bhe[0], t, "bus_bhe_n", bus_bhe_n, q_bhe[0]);
            chk(bus_we == is_wr, t, "bus_we", bus_we, is_wr);
            if (is_wr) chk(bus_wdata == q_wd[0], t, "bus_wdata", bus_wdata, q_wd[0]);
         end else begin
            chk(bus_cyc == 1'b0, "R6", "bus_cyc while idle", bus_cyc, 0);
         end
         chk(done == done_exp, "R6", "done", done, done_exp);
         if (done_exp && !done_wr) chk(rd_data == rd_exp, res_tag, "rd_data", rd_data, rd_exp);
         // advance to next edge
         old_busy = busy;
         done_exp = 0;
         if (busy && q_addr.size() > 0) begin
            if (bus_ack) begin
               b = (q_lane[0] == 1) ? bus_rdata[15:8] : bus_rdata[7:0];
               if (q_lane[0] == 2) acc = bus_rdata;
               else if (idx == 0)  acc[7:0] = b;
               else                acc[15:8] = b;
               void'(q_addr.pop_front()); void'(q_bhe.pop_front()); void'(q_wd.pop_front());
               void'(q_lane.pop_front()); void'(q_tag.pop_front());
               idx++;
               held = 0;
               if (q_addr.size() == 0) begin
                  done_exp = 1; busy = 0; rd_exp = acc; done_wr = is_wr;
               end
            end else begin
               held = 1;
            end
         end
         if (!old_busy && req_valid) begin
            a = req_addr;
            a1 = req_addr + 20'd1;
            acc = 16'h0; idx = 0; is_wr = req_write; busy = 1; held = 0;
            if (NARROW != 0) begin
               push(a, 1, {8'h00, req_wdata[7:0]}, 0, "R8");
               if (req_word) push(a1, 1, {8'h00, req_wdata[15:8]}, 0, (a == 20'hFFFFF) ? "R9" : "R8");
               res_tag = "R8";
            end else if (!req_word) begin
               if (!a[0]) begin push(a, 1, {8'h00, req_wdata[7:0]}, 0, "R1"); res_tag = "R1"; end
               else       begin push(a, 0, {req_wdata[7:0], 8'h00}, 1, "R2"); res_tag = "R2"; end
            end else if (!a[0]) begin
               push(a, 0, req_wdata, 2, "R3"); res_tag = "R3";
            end else begin
               push(a, 0, {req_wdata[7:0], 8'h00}, 1, "R4");
               push(a1, 1, {8'h00, req_wdata[15:8]}, 0, (a == 20'hFFFFF) ? "R9" : "R4");
               res_tag = "R5";
            end
         end
      end
   end

endmodule

// File: tb/byte_lane_ctrl_tb_top.sv
module byte_lane_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_word = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;

   logic        w_ready, w_cyc, w_bhe_n, w_we, w_ack, w_done;
   logic [19:0] w_addr;
   logic [15:0] w_wdata, w_rdata, w_rd;
   logic        n_ready, n_cyc, n_bhe_n, n_we, n_ack, n_done;
   logic [19:0] n_addr;
   logic [15:0] n_wdata, n_rdata, n_rd;
   logic [7:0]  w_lfsr, n_lfsr;

   int w_checks, w_errors, n_checks, n_errors;
   int extra_errors = 0;

   always #5 clk = ~clk;

   function automatic logic [15:0] mem_word(input logic [19:0] a);
      return {a[7:0] ^ 8'hC3, a[15:8] ^ a[7:0] ^ 8'h5A};
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_lfsr <= 8'h5B;
         n_lfsr <= 8'hA7;
      end else begin
         w_lfsr <= {w_lfsr[6:0], w_lfsr[7] ^ w_lfsr[5] ^ w_lfsr[4] ^ w_lfsr[3]};
         n_lfsr <= {n_lfsr[6:0], n_lfsr[7] ^ n_lfsr[5] ^ n_lfsr[4] ^ n_lfsr[3]};
      end
   end

   assign w_ack   = w_cyc & (w_lfsr[0] | w_lfsr[1]);
   assign n_ack   = n_cyc & (n_lfsr[0] | n_lfsr[2]);
   assign w_rdata = mem_word(w_addr);
   assign n_rdata = mem_word(n_addr);

   byte_lane_ctrl #(.ADDR_W(20), .LANE_W(8), .NARROW(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(w_ready),
      .req_addr(req_addr), .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
      .bus_cyc(w_cyc), .bus_addr(w_addr), .bus_bhe_n(w_bhe_n), .bus_we(w_we),
      .bus_wdata(w_wdata), .bus_ack(w_ack), .bus_rdata(w_rdata), .done(w_done), .rd_data(w_rd)
   );

   byte_lane_ctrl #(.ADDR_W(20), .LANE_W(8), .NARROW(1)) dut_n (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(n_ready),
      .req_addr(req_addr), .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
      .bus_cyc(n_cyc), .bus_addr(n_addr), .bus_bhe_n(n_bhe_n), .bus_we(n_we),
      .bus_wdata(n_wdata), .bus_ack(n_ack), .bus_rdata(n_rdata), .done(n_done), .rd_data(n_rd)
   );

   byte_lane_ctrl_ref #(.NARROW(0)) ref_w (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
      .req_write(req_write), .req_wdata(req_wdata), .req_ready(w_ready), .bus_cyc(w_cyc),
      .bus_addr(w_addr), .bus_bhe_n(w_bhe_n), .bus_we(w_we), .bus_wdata(w_wdata),
      .bus_ack(w_ack), .bus_rdata(w_rdata), .done(w_done), .rd_data(w_rd),
      .checks(w_checks), .errors(w_errors)
   );

   byte_lane_ctrl_ref #(.NARROW(1)) ref_n (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
      .req_write(req_write), .req_wdata(req_wdata), .req_ready(n_ready), .bus_cyc(n_cyc),
      .bus_addr(n_addr), .bus_bhe_n(n_bhe_n), .bus_we(n_we), .bus_wdata(n_wdata),
      .bus_ack(n_ack), .bus_rdata(n_rdata), .done(n_done), .rd_data(n_rd),
      .checks(n_checks), .errors(n_errors)
   );

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", w_checks + n_checks + 1, w_errors + n_errors + extra_errors);
      $finish;
   endtask

   task automatic send(input logic [19:0] a, input bit wd, input bit wr, input logic [15:0] d);
      forever begin
         @(posedge clk);
         #1;
         if (w_ready && n_ready) break;
      end
      req_valid = 1'b1;
      req_addr  = a;
      req_word  = wd;
      req_write = wr;
      req_wdata = d;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      req_wdata = ~d;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      send(20'h00000, 0, 1, 16'h1122);  // R1 even byte store
      send(20'h00000, 0, 0, 16'h0000);  // R1 even byte load
      send(20'h00001, 0, 1, 16'h3344);  // R2 odd byte store
      send(20'h00001, 0, 0, 16'h0000);  // R2 odd byte load
      send(20'h00002, 1, 1, 16'hA5C3);  // R3 even word store
      send(20'h00002, 1, 0, 16'h0000);  // R3 even word load
      send(20'h00003, 1, 1, 16'hBEEF);  // R4 odd word store
      send(20'h00003, 1, 0, 16'h0000);  // R5 odd word load
      send(20'hFFFFF, 1, 1, 16'hCAFE);  // R9 wrap store
      send(20'hFFFFF, 1, 0, 16'h0000);  // R9 wrap load
      send(20'hFFFFE, 1, 0, 16'h0000);  // R3 top even word
      send(20'hFFFFF, 0, 1, 16'h0077);  // R2 top byte
      for (int i = 0; i < 400; i++) begin
         logic [19:0] a;
         a = 20'($urandom);
         if (i % 37 == 0) a = 20'hFFFFF;
         send(a, 1'($urandom), 1'($urandom), 16'($urandom));
      end
      repeat (10) @(posedge clk);
      #1;
      if (!(w_ready && n_ready)) begin
         extra_errors++;
         $display("FAIL R6 final idle actual=%0b%0b expected=11", w_ready, n_ready);
      end
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      extra_errors++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      report();
   end

endmodule